// File: doc/BRIEF.md
# SMBus Control Register Slave

This block lets an SMBus host read and write a bank of 8-bit control registers. The host's SCL and SDA lines reach it as plain inputs that are sampled on the system clock. The block answers through a single SDA pull-down enable. The whole bank is presented in parallel to the logic around it. A one-cycle strobe per register marks each accepted write, so that a neighbour can start an action such as reloading a divider when a particular register is written.

The command byte selects the access form. With bit 7 set, the access is one register at the offset in bits 6:0. With bit 7 clear, the access is sequential and starts at register 0: a write then carries a byte count, and a read returns a byte count before the data. Power-on values and per-bit read-only masks are parameters, so identification and strap fields can be fixed in place.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges only an address byte whose upper seven bits equal DEV_ADDR (default 0x69, giving 0xD2 for write and 0xD3 for read). Any other address gets no acknowledge, and the bytes after it up to the next START or STOP get no acknowledge and change nothing.
- R2: A write command byte with bit 7 = 1 selects the register at the offset in bits 6:0. The data byte after it is written there, and exactly one wr_stb_o bit (bit = offset) pulses for one clock. Registers change only on their own strobe.
- R3: A register bit whose RO_MASK bit is 1 keeps its value through every write. A register bit whose mask bit is 0 takes the written bit.
- R4: Command 0x00 followed by a byte count and data writes the data bytes to registers 0, 1, 2, … in order. The slave acknowledges every byte. A STOP after any whole byte leaves the later registers untouched.
- R5: Command 0x80|offset, then a repeated START with the read address, returns that register most significant bit first. After the master's NACK and STOP, SDA is released.
- R6: Command 0x00, then a repeated START with the read address, returns the count NREG first and then registers 0, 1, 2, … for as long as the master acknowledges. After the master's NACK, SDA is released.
- R7: An offset at or above NREG is acknowledged on write but changes no register and pulses no strobe. A read at such an offset returns 0xFF.
- R8: After reset the bank holds INIT and SDA is released.
- R9: The pull-down turns on only while SCL is low. An acknowledge driven by the slave stays on through the whole SCL high period that follows.
- R10: A START in the middle of a byte abandons that byte without writing it and starts a fresh address phase.
- R11: A STOP returns the slave to idle with SDA released, and a following transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| regs_o | output | NREG*8 | Register bank, register k in bits k*8+7:k*8 |
| wr_stb_o | output | NREG | One-clock write strobe per register |

## Verification
A wrong bit counter or byte phase shows up on the bus within one byte. The acknowledge lands in the wrong SCL slot, or read data comes out shifted by a bit. A wrong offset pointer shows up either as a wrong register value on regs_o as soon as the write's acknowledge begins, or as a strobe on the wrong bit in that same clock. A state that misses START or STOP is caught by the next transaction, which is then not acknowledged or writes to the wrong place. The reference bank in the bench is compared with regs_o on every idle clock, and the bench counts strobes per register for each transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK
  } smb_state_t;

  typedef enum logic [1:0] {
    B_ADDR,
    B_CMD,
    B_CNT,
    B_DATA
  } smb_byte_t;

  // protected bits keep their old value, the others take the new value
  function automatic logic [7:0] byte_merge(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] keep);
    return (new_v & ~keep) | (old_v & keep);
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_q, sda_q;
  logic       scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 2'b11;
      sda_q <= 2'b11;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[0], scl_i};
      sda_q <= {sda_q[0], sda_i};
      scl_p <= scl_q[1];
      sda_p <= sda_q[1];
    end
  end

  assign scl_s    = scl_q[1];
  assign sda_s    = sda_q[1];
  assign scl_rise = scl_q[1] & ~scl_p;
  assign scl_fall = ~scl_q[1] & scl_p;
  assign start_ev = scl_q[1] & scl_p & sda_p & ~sda_q[1];
  assign stop_ev  = scl_q[1] & scl_p & ~sda_p & sda_q[1];

  a_r10_no_start_and_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NREG = 16,
  parameter logic [NREG*8-1:0] INIT    = '0,
  parameter logic [NREG*8-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [6:0]        wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [6:0]        rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] bank,
  output logic [NREG-1:0]   wr_stb
);
  import smb_pkg::*;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_stb
      assign wr_stb[g] = wr_en && (wr_idx == 7'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank <= INIT;
    end else begin
      for (int k = 0; k < NREG; k++) begin
        if (wr_stb[k])
          bank[k*8 +: 8] <= byte_merge(bank[k*8 +: 8], wr_data, RO_MASK[k*8 +: 8]);
      end
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int k = 0; k < NREG; k++) begin
      if (rd_idx == 7'(k)) rd_data = bank[k*8 +: 8];
    end
  end

  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb));

  a_r7_no_strobe_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_idx) >= NREG)) |-> (wr_stb == '0));

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_chk
      a_r2_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb[g] |=> $stable(bank[g*8 +: 8]));
      a_r3_protected_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb[g] |=> ((bank[g*8 +: 8] & RO_MASK[g*8 +: 8]) ==
                       ($past(bank[g*8 +: 8]) & RO_MASK[g*8 +: 8])));
    end
  endgenerate
endmodule

// File: rtl/smb_ctrl.sv
module smb_ctrl #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NREG     = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_s,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [7:0] rd_data,
  output logic [6:0] rd_idx,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_pull
);
  import smb_pkg::*;

  smb_state_t st;
  smb_byte_t  kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [6:0] ptr;
  logic       reading;
  logic       blk_pend;
  logic       m_ack;

  // named events for the checks
  logic       byte_in_done;
  logic       addr_hit;
  logic [7:0] tx_next;

  assign byte_in_done = (st == S_RX) && (bitcnt == 4'd8) && scl_fall;
  assign addr_hit     = (shreg[7:1] == DEV_ADDR);
  assign tx_next      = blk_pend ? 8'(NREG) : rd_data;
  assign rd_idx       = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= B_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      ptr      <= '0;
      reading  <= 1'b0;
      blk_pend <= 1'b0;
      m_ack    <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_ev) begin
        st       <= S_IDLE;
        sda_pull <= 1'b0;
        blk_pend <= 1'b0;
      end else if (start_ev) begin
        st       <= S_RX;
        kind     <= B_ADDR;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_in_done) begin
              bitcnt <= '0;
              case (kind)
                B_ADDR: begin
                  if (addr_hit) begin
                    sda_pull <= 1'b1;
                    st       <= S_RXACK;
                    reading  <= shreg[0];
                    kind     <= B_CMD;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                B_CMD: begin
                  sda_pull <= 1'b1;
                  st       <= S_RXACK;
                  if (shreg[7]) begin
                    ptr      <= shreg[6:0];
                    kind     <= B_DATA;
                    blk_pend <= 1'b0;
                  end else begin
                    ptr      <= '0;
                    kind     <= B_CNT;
                    blk_pend <= 1'b1;
                  end
                end
                B_CNT: begin
                  sda_pull <= 1'b1;
                  st       <= S_RXACK;
                  kind     <= B_DATA;
                end
                default: begin
                  sda_pull <= 1'b1;
                  st       <= S_RXACK;
                  wr_en    <= 1'b1;
                  wr_idx   <= ptr;
                  wr_data  <= shreg;
                  ptr      <= ptr + 7'd1;
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (reading) begin
                shreg    <= tx_next;
                sda_pull <= ~tx_next[7];
                st       <= S_TX;
                if (blk_pend) blk_pend <= 1'b0;
                else          ptr      <= ptr + 7'd1;
              end else begin
                sda_pull <= 1'b0;
                st       <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_pull <= 1'b0;
                m_ack    <= 1'b0;
                st       <= S_TXACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_pull <= ~shreg[6];
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              bitcnt <= '0;
              if (m_ack) begin
                shreg    <= tx_next;
                sda_pull <= ~tx_next[7];
                st       <= S_TX;
                if (blk_pend) blk_pend <= 1'b0;
                else          ptr      <= ptr + 7'd1;
              end else begin
                sda_pull <= 1'b0;
                st       <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r9_pull_rises_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);

  a_r9_ack_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RXACK && scl_s) |-> sda_pull);

  a_r11_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == S_IDLE && !sda_pull));

  a_r1_foreign_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in_done && kind == B_ADDR && !addr_hit && !start_ev && !stop_ev) |=> !sda_pull);

  a_r10_start_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (st == S_RX && kind == B_ADDR && bitcnt == 4'd0));
endmodule

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter int                NREG     = 16,
  parameter logic [NREG*8-1:0] INIT     = 128'h0000000000000000_080000003FFF0F00,
  parameter logic [NREG*8-1:0] RO_MASK  = 128'h0000000000000000_FF00000000000081
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [NREG*8-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0] rd_data, wr_data;
  logic [6:0] rd_idx, wr_idx;
  logic       wr_en;

  smb_line_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_ctrl #(.DEV_ADDR(DEV_ADDR), .NREG(NREG)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_pull (sda_pull_o)
  );

  smb_regbank #(.NREG(NREG), .INIT(INIT), .RO_MASK(RO_MASK)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .bank    (regs_o),
    .wr_stb  (wr_stb_o)
  );
endmodule

// File: tb/sim_smb_regslave.sv
module sim_smb_regslave;
  localparam int CLK_NS = 10;
  localparam int Q      = 5;
  localparam int NR     = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull;
  logic [NR*8-1:0] regs;
  logic [NR-1:0]   stb;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_pull;

  smb_regslave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .regs_o(regs), .wr_stb_o(stb)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_r [NR];
  int stb_seen [NR];
  int stb_exp  [NR];
  bit busy = 1'b1;
  bit done = 1'b0;
  int r9_viol = 0, idle_viol = 0;
  logic prev_pull = 1'b0;

  function automatic logic [7:0] def_of(int i);
    case (i)
      1: return 8'h0F;
      2: return 8'hFF;
      3: return 8'h3F;
      7: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] ro_of(int i);
    case (i)
      0: return 8'h81;
      7: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // model of one accepted write
  task automatic model_wr(input int i, input logic [7:0] v);
    if (i < NR) begin
      for (int b = 0; b < 8; b++)
        if (!ro_of(i)[b]) exp_r[i][b] = v[b];
      stb_exp[i]++;
    end
  endtask

  always @(posedge clk) begin
    for (int i = 0; i < NR; i++) if (stb[i]) stb_seen[i]++;
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull && !prev_pull && m_scl) r9_viol++;
      if (!busy) begin
        for (int i = 0; i < NR; i++)
          if (regs[i*8 +: 8] !== exp_r[i]) idle_viol++;
      end
    end
    prev_pull = sda_pull;
  end

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bstart();
    busy = 1'b1;
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic brestart();
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); m_sda = 1'b0; q(); m_scl = 1'b0; q();
  endtask

  task automatic bstop();
    m_sda = 1'b0; q(); m_scl = 1'b1; q(); m_sda = 1'b1; q(); q(); q();
    busy = 1'b0;
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, output bit ack);
    tx_bits(b, 8);
    m_sda = 1'b1; q(); m_scl = 1'b1; q(); ack = !sda_bus; q(); m_scl = 1'b0; q();
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      m_scl = 1'b1; q(); b[i] = sda_bus; q(); m_scl = 1'b0; q();
    end
    m_sda = give_ack ? 1'b0 : 1'b1; q(); m_scl = 1'b1; q(); q(); m_scl = 1'b0; q();
    m_sda = 1'b1;
  endtask

  task automatic send_ack(input logic [7:0] b, input string req);
    bit a;
    tx_byte(b, a);
    chk(a == 1'b1, req, "byte acknowledged", int'(a), 1);
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NR; i++) begin
      chk(regs[i*8 +: 8] == exp_r[i], req, $sformatf("reg %0d value", i),
          int'(regs[i*8 +: 8]), int'(exp_r[i]));
      chk(stb_seen[i] == stb_exp[i], req, $sformatf("reg %0d strobe count", i),
          stb_seen[i], stb_exp[i]);
      stb_seen[i] = 0;
      stb_exp[i] = 0;
    end
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] v, input string req);
    bstart(); send_ack(8'hD2, req); send_ack({1'b1, off}, req); send_ack(v, req); bstop();
    model_wr(int'(off), v);
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] v, input string req);
    bstart(); send_ack(8'hD2, req); send_ack({1'b1, off}, req);
    brestart(); send_ack(8'hD3, req); rx_byte(1'b0, v); bstop();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) begin
      exp_r[i] = def_of(i);
      stb_seen[i] = 0;
      stb_exp[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    busy = 1'b0;

    // R8 reset state
    chk(sda_pull == 1'b0, "R8", "sda released after reset", int'(sda_pull), 0);
    check_bank("R8");

    // R2 byte write, R3 protected bits
    byte_write(7'd2, 8'hA5, "R2");
    check_bank("R2");
    byte_write(7'd7, 8'h00, "R3");
    byte_write(7'd0, 8'hFF, "R3");
    check_bank("R3");

    // R5 byte read
    begin
      logic [7:0] v;
      byte_read(7'd2, v, "R5");
      chk(v == exp_r[2], "R5", "read data", int'(v), int'(exp_r[2]));
      chk(sda_pull == 1'b0, "R5", "sda released after read", int'(sda_pull), 0);
      byte_read(7'd7, v, "R5");
      chk(v == exp_r[7], "R5", "read of id register", int'(v), int'(exp_r[7]));
    end

    // R4 block write, full then partial
    bstart(); send_ack(8'hD2, "R4"); send_ack(8'h00, "R4"); send_ack(8'd4, "R4");
    send_ack(8'h11, "R4"); send_ack(8'h22, "R4"); send_ack(8'h33, "R4"); send_ack(8'h44, "R4");
    bstop();
    model_wr(0, 8'h11); model_wr(1, 8'h22); model_wr(2, 8'h33); model_wr(3, 8'h44);
    check_bank("R4");
    bstart(); send_ack(8'hD2, "R4"); send_ack(8'h00, "R4"); send_ack(8'd5, "R4");
    send_ack(8'hAA, "R4"); send_ack(8'hBB, "R4");
    bstop();
    model_wr(0, 8'hAA); model_wr(1, 8'hBB);
    check_bank("R4");

    // R6 block read
    begin
      logic [7:0] v;
      bstart(); send_ack(8'hD2, "R6"); send_ack(8'h00, "R6");
      brestart(); send_ack(8'hD3, "R6");
      rx_byte(1'b1, v);
      chk(v == 8'(NR), "R6", "block count", int'(v), NR);
      for (int i = 0; i < NR; i++) begin
        rx_byte(i != NR - 1, v);
        chk(v == exp_r[i], "R6", $sformatf("block byte %0d", i), int'(v), int'(exp_r[i]));
      end
      chk(sda_pull == 1'b0, "R6", "sda released after nack", int'(sda_pull), 0);
      bstop();
    end

    // R1 foreign address
    begin
      bit a;
      bstart();
      tx_byte(8'hA0, a); chk(a == 1'b0, "R1", "foreign address nack", int'(a), 0);
      tx_byte(8'h82, a); chk(a == 1'b0, "R1", "following byte nack", int'(a), 0);
      tx_byte(8'h5C, a); chk(a == 1'b0, "R1", "data byte nack", int'(a), 0);
      bstop();
      check_bank("R1");
    end

    // R7 out-of-range offset
    begin
      logic [7:0] v;
      byte_write(7'h20, 8'h77, "R7");
      check_bank("R7");
      byte_read(7'h20, v, "R7");
      chk(v == 8'hFF, "R7", "out-of-range read", int'(v), 8'hFF);
    end

    // R10 start inside a byte
    bstart(); send_ack(8'hD2, "R10"); send_ack(8'h83, "R10");
    tx_bits(8'h00, 4);
    brestart(); send_ack(8'hD2, "R10"); send_ack(8'h84, "R10"); send_ack(8'h5A, "R10");
    bstop();
    model_wr(4, 8'h5A);
    check_bank("R10");

    // R11 stop after command, then a normal transaction
    bstart(); send_ack(8'hD2, "R11"); send_ack(8'h85, "R11"); bstop();
    chk(sda_pull == 1'b0, "R11", "sda released after stop", int'(sda_pull), 0);
    byte_write(7'd5, 8'hC3, "R11");
    check_bank("R11");

    chk(r9_viol == 0, "R9", "pull-down rises while scl high", r9_viol, 0);
    chk(idle_viol == 0, "R2", "idle bank mismatches", idle_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule